// File: doc/BRIEF.md
# UART FIFO Trigger-Interrupt Controller

This block is the FIFO core of a 16550-class serial port. It holds a 16-byte transmit queue and a 16-byte receive queue. It decodes an 8-bit FIFO control byte written by the host. From the fill of each queue and a programmable trigger level, it raises two interrupt requests. The serial shift registers, the baud generator, line framing and the interrupt priority encoder sit outside the block. They connect to it only through the queue push and pop ports.

The control byte turns the queues on or off. It can also empty either queue through a request bit that clears itself. It holds a stored DMA-mode flag and two 2-bit trigger-code fields. The transmit field can only be changed while an enhanced-feature enable input is high. A single trigger level serves both directions. It follows whichever of the two fields most recently took a new value. The receive request follows the receive fill against that level. The transmit request remembers whether the last refill rose above the level. If it did, the request fires when the fill drops below the level. If it did not, the request fires when the queue drains empty.

Top module: `uart_fifo_trig_ctrl`

## Requirements
- R1: After reset, both counts are 0 and the queues are disabled. Trigger level is 1, dma_mode is 0 and the control readback is 8'h00. tx_irq is 1, rx_irq is 0, and both overflow flags and both read-data outputs are 0.
- R2: When enabled, each queue accepts up to 16 bytes and returns them in write order on rd_data one cycle after an accepted pop. Count tracks accepted pushes minus accepted pops, and full is high at 16.
- R3: A push while full is dropped and sets that queue's sticky overflow flag. A pop while empty leaves the count at 0 and read data unchanged.
- R4: Control bit 1 empties the receive queue and bit 2 empties the transmit queue, clearing count and overflow but not read data. Each acts only when bit 0 is 1 in the same write, and readback bits 2:1 are always 0.
- R5: A write whose bit 0 differs from the current enable state empties both queues. While disabled each queue holds at most one byte and the trigger level is 1.
- R6: Control bit 3 is stored, drives dma_mode and reads back in bit 3. It has no other effect.
- R7: Readback bits 7:6 hold the receive code and bits 5:4 the transmit code, with codes 00/01/10/11 giving levels 1/4/8/14. Bits 5:4 of a write are ignored while efr_enh is 0.
- R8: The trigger level comes from the field that most recently changed value. If both change in one write, the receive field wins.
- R9: rx_irq is high exactly while the receive count is at or above the trigger level.
- R10: A transmit pop sets tx_irq if either (a) a push since the last tx_irq raised the count above the level and the pop leaves the count below the level, or (b) no such push happened and the pop leaves the queue empty.
- R11: An accepted transmit push clears tx_irq, and emptying the transmit queue through a control write sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fcr_we | input | 1 | Control byte write strobe |
| fcr_wdata | input | 8 | Control byte written |
| efr_enh | input | 1 | Enhanced-feature enable; unlocks the transmit trigger field |
| tx_push | input | 1 | Write a byte into the transmit queue |
| tx_wdata | input | 8 | Transmit byte |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_rdata | output | 8 | Last byte taken from the transmit queue |
| tx_count | output | 5 | Transmit fill |
| tx_full | output | 1 | Transmit queue full |
| tx_overflow | output | 1 | Sticky transmit overflow |
| tx_irq | output | 1 | Transmit request |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads a byte |
| rx_rdata | output | 8 | Last byte read from the receive queue |
| rx_count | output | 5 | Receive fill |
| rx_full | output | 1 | Receive queue full |
| rx_overflow | output | 1 | Sticky receive overflow |
| rx_irq | output | 1 | Receive request |
| fifo_en | output | 1 | Queues enabled |
| dma_mode | output | 1 | Stored DMA-mode flag |
| trig_level | output | 5 | Active trigger level in characters |
| fcr_rdata | output | 8 | Control readback |

## Verification
The transmit request is tested with two directed refill shapes at level 4. A shallow refill to 2 bytes must stay quiet until the queue drains empty. A deep refill to 6 bytes must fire at 3, one below the level. The two shapes separate the remembered-reload rule from a plain threshold compare. Trigger selection is tested by writes that change only the receive field, only the transmit field, and both at once, with efr_enh low and high. This separates last-changed-field priority from fixed-field selection. Random push, pop and control traffic, including writes that clear the queues, toggle enable and hit full or empty, is compared every cycle against a queue-based model. This covers ordering, drops and clear-versus-push priority.

// File: rtl/uft_pkg.sv
// Package: shared constants and trigger decoding for the FIFO trigger controller.
// Assumes byte-wide queues and the fixed four trigger levels of a 16550-class port.
package uft_pkg;

    // Bit positions inside the control byte; the host software depends on these.
    localparam int unsigned CB_EN    = 0;
    localparam int unsigned CB_RXCLR = 1;
    localparam int unsigned CB_TXCLR = 2;
    localparam int unsigned CB_DMA   = 3;
    localparam int unsigned CB_TXLO  = 4;
    localparam int unsigned CB_RXLO  = 6;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_code_e;

    // Map a 2-bit trigger code to a character count.
    function automatic int unsigned trig_chars(input logic [1:0] code);
        case (trig_code_e'(code))
            TRIG_ONE:   return 1;
            TRIG_FOUR:  return 4;
            TRIG_EIGHT: return 8;
            default:    return 14;
        endcase
    endfunction

endpackage

// File: rtl/uft_ctrl.sv
// Module: control byte decoder.
// Holds enable, DMA flag and both trigger codes; produces one-cycle queue
// clear strobes and the single shared trigger level. Assumes fcr_we is a
// single-cycle strobe; clear strobes are combinational from that write.
module uft_ctrl #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [7:0]    wdata,
    input  logic          enh,
    output logic          fifo_en,
    output logic          dma_mode,
    output logic          clr_rx,
    output logic          clr_tx,
    output logic [CW-1:0] trig_level,
    output logic [7:0]    rdata
);
    import uft_pkg::*;

    logic       en_q;
    logic       dma_q;
    logic [1:0] rx_code_q;
    logic [1:0] tx_code_q;
    logic       use_tx_q;
    logic [1:0] rx_code_n;
    logic [1:0] tx_code_n;
    logic       en_flip;
    logic       rx_changed;
    logic       tx_changed;
    logic [1:0] sel_code;

    // Decode the incoming write: new codes, change flags, clear strobes.
    always_comb begin
        rx_code_n  = wdata[CB_RXLO +: 2];
        tx_code_n  = enh ? wdata[CB_TXLO +: 2] : tx_code_q;
        rx_changed = we && (rx_code_n != rx_code_q);
        tx_changed = we && (tx_code_n != tx_code_q);
        en_flip    = we && (wdata[CB_EN] != en_q);
        clr_rx     = (we && wdata[CB_EN] && wdata[CB_RXCLR]) || en_flip;
        clr_tx     = (we && wdata[CB_EN] && wdata[CB_TXCLR]) || en_flip;
    end

    // Store the control fields and remember which trigger field moved last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            dma_q     <= 1'b0;
            rx_code_q <= 2'b00;
            tx_code_q <= 2'b00;
            use_tx_q  <= 1'b0;
        end else if (we) begin
            en_q      <= wdata[CB_EN];
            dma_q     <= wdata[CB_DMA];
            rx_code_q <= rx_code_n;
            tx_code_q <= tx_code_n;
            if (rx_changed)
                use_tx_q <= 1'b0;
            else if (tx_changed)
                use_tx_q <= 1'b1;
        end
    end

    // Resolve the shared level; character mode forces a level of one.
    always_comb begin
        sel_code   = use_tx_q ? tx_code_q : rx_code_q;
        trig_level = en_q ? CW'(trig_chars(sel_code)) : CW'(1);
    end

    // Readback: the clear request bits always read as zero.
    always_comb begin
        rdata            = 8'h00;
        rdata[CB_EN]     = en_q;
        rdata[CB_DMA]    = dma_q;
        rdata[CB_TXLO +: 2] = tx_code_q;
        rdata[CB_RXLO +: 2] = rx_code_q;
    end

    assign fifo_en  = en_q;
    assign dma_mode = dma_q;

endmodule

// File: rtl/uft_fifo.sv
// Module: byte queue with single-entry character mode.
// Drops pushes when full (sticky overflow), ignores pops when empty and
// keeps the last popped byte on rdata. A clear empties pointers, count and
// overflow only; storage and rdata are left as they were. Clear beats push/pop.
module uft_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cap_one,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          overflow,
    output logic          push_ok,
    output logic          pop_ok
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Accept decisions from the current fill and the active capacity.
    always_comb begin
        full    = cap_one ? (count != '0) : (count == CW'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && (count != '0);
    end

    // Storage: one write-enabled register per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && !clr && (wr_ptr == AW'(g)))
                mem[g] <= wdata;
        end
    end

    // Pointer, count and overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else if (clr) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && full)
                overflow <= 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Output register: holds the most recently popped byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (pop_ok && !clr)
            rdata <= mem[rd_ptr];
    end

endmodule

// File: rtl/uft_irq.sv
// Module: receive and transmit trigger requests.
// Receive: level compare of fill against the trigger. Transmit: an armed
// flag records whether the refill since the last request rose above the
// trigger; a pop then fires below the trigger (armed) or at empty (not armed).
// Assumes push_ok/pop_ok come from the transmit queue's accept logic.
module uft_irq #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_clr,
    input  logic          tx_push_ok,
    input  logic          tx_pop_ok,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] trig_level,
    output logic          tx_irq,
    output logic          rx_irq
);
    logic          armed_q;
    logic          tx_irq_q;
    logic [CW-1:0] tx_next;
    logic          fire;

    // Fill the transmit queue will hold after this cycle.
    always_comb begin
        tx_next = tx_count;
        if (tx_push_ok && !tx_pop_ok)
            tx_next = tx_count + 1'b1;
        else if (tx_pop_ok && !tx_push_ok)
            tx_next = tx_count - 1'b1;
        fire = armed_q ? (tx_next < trig_level) : (tx_next == '0);
    end

    // Transmit request and reload memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_irq_q <= 1'b1;
            armed_q  <= 1'b0;
        end else if (tx_clr) begin
            tx_irq_q <= 1'b1;
            armed_q  <= 1'b0;
        end else if (tx_push_ok) begin
            tx_irq_q <= 1'b0;
            if (tx_next > trig_level)
                armed_q <= 1'b1;
        end else if (tx_pop_ok && fire) begin
            tx_irq_q <= 1'b1;
            armed_q  <= 1'b0;
        end
    end

    assign tx_irq = tx_irq_q;
    assign rx_irq = (rx_count >= trig_level);

endmodule

// File: rtl/uart_fifo_trig_ctrl.sv
// Module: top of the UART FIFO trigger-interrupt controller.
// Wires the control decoder, the two byte queues and the request logic.
// Assumes a single clock domain and a synchronous active-low reset.
module uart_fifo_trig_ctrl #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fcr_we,
    input  logic [7:0]                   fcr_wdata,
    input  logic                         efr_enh,
    input  logic                         tx_push,
    input  logic [DW-1:0]                tx_wdata,
    input  logic                         tx_pop,
    output logic [DW-1:0]                tx_rdata,
    output logic [$clog2(DEPTH+1)-1:0]   tx_count,
    output logic                         tx_full,
    output logic                         tx_overflow,
    output logic                         tx_irq,
    input  logic                         rx_push,
    input  logic [DW-1:0]                rx_wdata,
    input  logic                         rx_pop,
    output logic [DW-1:0]                rx_rdata,
    output logic [$clog2(DEPTH+1)-1:0]   rx_count,
    output logic                         rx_full,
    output logic                         rx_overflow,
    output logic                         rx_irq,
    output logic                         fifo_en,
    output logic                         dma_mode,
    output logic [$clog2(DEPTH+1)-1:0]   trig_level,
    output logic [7:0]                   fcr_rdata
);
    localparam int CW = $clog2(DEPTH + 1);

    logic clr_rx;
    logic clr_tx;
    logic tx_push_ok;
    logic tx_pop_ok;
    logic rx_push_ok;
    logic rx_pop_ok;

    uft_ctrl #(.CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (fcr_we),
        .wdata      (fcr_wdata),
        .enh        (efr_enh),
        .fifo_en    (fifo_en),
        .dma_mode   (dma_mode),
        .clr_rx     (clr_rx),
        .clr_tx     (clr_tx),
        .trig_level (trig_level),
        .rdata      (fcr_rdata)
    );

    uft_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_tx),
        .cap_one  (!fifo_en),
        .push     (tx_push),
        .wdata    (tx_wdata),
        .pop      (tx_pop),
        .rdata    (tx_rdata),
        .count    (tx_count),
        .full     (tx_full),
        .overflow (tx_overflow),
        .push_ok  (tx_push_ok),
        .pop_ok   (tx_pop_ok)
    );

    uft_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_rx),
        .cap_one  (!fifo_en),
        .push     (rx_push),
        .wdata    (rx_wdata),
        .pop      (rx_pop),
        .rdata    (rx_rdata),
        .count    (rx_count),
        .full     (rx_full),
        .overflow (rx_overflow),
        .push_ok  (rx_push_ok),
        .pop_ok   (rx_pop_ok)
    );

    uft_irq #(.CW(CW)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_clr     (clr_tx),
        .tx_push_ok (tx_push_ok),
        .tx_pop_ok  (tx_pop_ok),
        .tx_count   (tx_count),
        .rx_count   (rx_count),
        .trig_level (trig_level),
        .tx_irq     (tx_irq),
        .rx_irq     (rx_irq)
    );

endmodule

// File: rtl/uft_chk.sv
// Module: property checker bound to the controller top; observes ports only.
module uft_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fcr_we,
    input logic [7:0]    fcr_wdata,
    input logic          efr_enh,
    input logic          tx_push,
    input logic          tx_full,
    input logic          tx_irq,
    input logic [CW-1:0] tx_count,
    input logic          rx_push,
    input logic          rx_pop,
    input logic [7:0]    rx_rdata,
    input logic [CW-1:0] rx_count,
    input logic          rx_full,
    input logic          rx_overflow,
    input logic          rx_irq,
    input logic          fifo_en,
    input logic [CW-1:0] trig_level,
    input logic [7:0]    fcr_rdata
);
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_pop && !fcr_we) |=> (rx_overflow && $stable(rx_count)));

    a_r3_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && (rx_count == '0) && !fcr_we) |=> ((rx_count == '0) && $stable(rx_rdata)));

    a_r4_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_we && fcr_wdata[0] && fcr_wdata[1]) |=> ((rx_count == '0) && !rx_overflow));

    a_r5_enable_flip_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_we && (fcr_wdata[0] != fifo_en)) |=> ((rx_count == '0) && (tx_count == '0)));

    a_r5_char_mode_depth: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> ((rx_count <= CW'(1)) && (tx_count <= CW'(1))));

    a_r7_tx_field_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_we && !efr_enh) |=> $stable(fcr_rdata[5:4]));

    a_r9_rx_drop_below: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && !fcr_we && (rx_count == trig_level)) |=> !rx_irq);

    a_r11_push_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !tx_full && !fcr_we) |=> !tx_irq);

endmodule

bind uart_fifo_trig_ctrl uft_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fcr_we      (fcr_we),
    .fcr_wdata   (fcr_wdata),
    .efr_enh     (efr_enh),
    .tx_push     (tx_push),
    .tx_full     (tx_full),
    .tx_irq      (tx_irq),
    .tx_count    (tx_count),
    .rx_push     (rx_push),
    .rx_pop      (rx_pop),
    .rx_rdata    (rx_rdata),
    .rx_count    (rx_count),
    .rx_full     (rx_full),
    .rx_overflow (rx_overflow),
    .rx_irq      (rx_irq),
    .fifo_en     (fifo_en),
    .trig_level  (trig_level),
    .fcr_rdata   (fcr_rdata)
);

// File: tb/uart_fifo_trig_ctrl_test.sv
`timescale 1ns/1ps
module uart_fifo_trig_ctrl_test;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fcr_we = 1'b0;
    logic [7:0] fcr_wdata = 8'h00;
    logic       efr_enh = 1'b0;
    logic       tx_push = 1'b0;
    logic [7:0] tx_wdata = 8'h00;
    logic       tx_pop = 1'b0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_wdata = 8'h00;
    logic       rx_pop = 1'b0;
    logic [7:0] tx_rdata, rx_rdata, fcr_rdata;
    logic [4:0] tx_count, rx_count, trig_level;
    logic       tx_full, tx_overflow, tx_irq, rx_full, rx_overflow, rx_irq;
    logic       fifo_en, dma_mode;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    uart_fifo_trig_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
        .efr_enh(efr_enh), .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_full(tx_full),
        .tx_overflow(tx_overflow), .tx_irq(tx_irq), .rx_push(rx_push),
        .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_count(rx_count), .rx_full(rx_full), .rx_overflow(rx_overflow),
        .rx_irq(rx_irq), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .trig_level(trig_level), .fcr_rdata(fcr_rdata)
    );

    // ---------------- reference model ----------------
    bit       m_en, m_dma, m_use_tx, m_rx_ovf, m_tx_ovf, m_tx_irq, m_armed;
    bit [1:0] m_rxs, m_txs;
    byte unsigned m_rxq[$], m_txq[$];
    byte unsigned m_rx_rd, m_tx_rd;

    function automatic int lvl(bit [1:0] c);
        case (c)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int m_level();
        return m_en ? lvl(m_use_tx ? m_txs : m_rxs) : 1;
    endfunction

    function automatic void m_reset();
        m_en = 0; m_dma = 0; m_use_tx = 0; m_rx_ovf = 0; m_tx_ovf = 0;
        m_tx_irq = 1; m_armed = 0; m_rxs = 0; m_txs = 0;
        m_rxq.delete(); m_txq.delete(); m_rx_rd = 0; m_tx_rd = 0;
    endfunction

    // Next model state from the inputs applied in this cycle.
    function automatic void m_step();
        int  cap = m_en ? DEPTH : 1;
        int  lv  = m_level();
        bit  flip = fcr_we && (fcr_wdata[0] != m_en);
        bit  crx  = (fcr_we && fcr_wdata[0] && fcr_wdata[1]) || flip;
        bit  ctx  = (fcr_we && fcr_wdata[0] && fcr_wdata[2]) || flip;
        bit  full, pok, uok;
        bit [1:0] nrx, ntx;
        if (crx) begin
            m_rxq.delete(); m_rx_ovf = 0;
        end else begin
            full = m_rxq.size() >= cap;
            pok  = rx_pop && (m_rxq.size() > 0);
            uok  = rx_push && !full;
            if (rx_push && full) m_rx_ovf = 1;
            if (pok) m_rx_rd = m_rxq.pop_front();
            if (uok) m_rxq.push_back(rx_wdata);
        end
        if (ctx) begin
            m_txq.delete(); m_tx_ovf = 0; m_tx_irq = 1; m_armed = 0;
        end else begin
            full = m_txq.size() >= cap;
            pok  = tx_pop && (m_txq.size() > 0);
            uok  = tx_push && !full;
            if (tx_push && full) m_tx_ovf = 1;
            if (pok) m_tx_rd = m_txq.pop_front();
            if (uok) m_txq.push_back(tx_wdata);
            if (uok) begin
                m_tx_irq = 0;
                if (m_txq.size() > lv) m_armed = 1;
            end else if (pok) begin
                if ((m_armed && m_txq.size() < lv) || (!m_armed && m_txq.size() == 0)) begin
                    m_tx_irq = 1; m_armed = 0;
                end
            end
        end
        if (fcr_we) begin
            nrx = fcr_wdata[7:6];
            ntx = efr_enh ? fcr_wdata[5:4] : m_txs;
            if (nrx != m_rxs) m_use_tx = 0;
            else if (ntx != m_txs) m_use_tx = 1;
            m_rxs = nrx; m_txs = ntx; m_en = fcr_wdata[0]; m_dma = fcr_wdata[3];
        end
    endfunction

    // ---------------- checking ----------------
    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic compare_all();
        int lv = m_level();
        chk("R2 rx_count", rx_count, m_rxq.size());
        chk("R2 tx_count", tx_count, m_txq.size());
        chk("R2 rx_full", rx_full, m_rxq.size() >= (m_en ? DEPTH : 1));
        chk("R2 tx_full", tx_full, m_txq.size() >= (m_en ? DEPTH : 1));
        chk("R3 rx_overflow", rx_overflow, m_rx_ovf);
        chk("R3 tx_overflow", tx_overflow, m_tx_ovf);
        chk("R2 rx_rdata", rx_rdata, m_rx_rd);
        chk("R2 tx_rdata", tx_rdata, m_tx_rd);
        chk("R8 trig_level", trig_level, lv);
        chk("R7 fcr_rdata", fcr_rdata, {m_rxs, m_txs, m_dma, 2'b00, m_en});
        chk("R6 dma_mode", dma_mode, m_dma);
        chk("R9 rx_irq", rx_irq, m_rxq.size() >= lv);
        chk("R10 tx_irq", tx_irq, m_tx_irq);
    endtask

    task automatic idle();
        fcr_we = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    endtask

    task automatic cyc();
        m_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        idle();
    endtask

    task automatic wr(input logic [7:0] v, input logic enh);
        fcr_we = 1; fcr_wdata = v; efr_enh = enh; cyc();
    endtask
    task automatic tpush(input logic [7:0] d); tx_push = 1; tx_wdata = d; cyc(); endtask
    task automatic tpop();  tx_pop = 1; cyc(); endtask
    task automatic rpush(input logic [7:0] d); rx_push = 1; rx_wdata = d; cyc(); endtask
    task automatic rpop();  rx_pop = 1; cyc(); endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual running expected done");
        finish_up();
    end

    initial begin
        void'($urandom(32'd24681));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_count", rx_count, 0);
        chk("R1 tx_count", tx_count, 0);
        chk("R1 tx_irq", tx_irq, 1);
        chk("R1 rx_irq", rx_irq, 0);
        chk("R1 trig_level", trig_level, 1);
        chk("R1 fcr_rdata", fcr_rdata, 0);
        chk("R1 fifo_en", fifo_en, 0);
        chk("R1 dma_mode", dma_mode, 0);
        chk("R1 rx_overflow", rx_overflow, 0);
        chk("R1 rx_rdata", rx_rdata, 0);

        // R5 character mode: one byte deep
        rpush(8'h11); rpush(8'h22);
        chk("R5 disabled rx_count", rx_count, 1);
        chk("R5 disabled overflow", rx_overflow, 1);
        // R4 clear ignored without bit 0 (no enable change)
        wr(8'h02, 0);
        chk("R4 clear needs enable bit", rx_count, 1);
        // R5 enabling flips the mode and clears
        wr(8'h01, 0);
        chk("R5 enable clears count", rx_count, 0);
        chk("R5 enable clears overflow", rx_overflow, 0);

        // R2/R3 fill transmit, drop on full, drain in order
        for (int i = 0; i < DEPTH; i++) tpush(8'hA0 + 8'(i));
        chk("R2 tx full at 16", tx_full, 1);
        tpush(8'h5A);
        chk("R3 tx drop count", tx_count, DEPTH);
        chk("R3 tx overflow set", tx_overflow, 1);
        for (int i = 0; i < DEPTH; i++) begin
            tpop();
            chk("R2 tx order", tx_rdata, 8'hA0 + 8'(i));
        end
        tpop();
        chk("R3 empty pop rdata", tx_rdata, 8'hAF);
        chk("R3 empty pop count", tx_count, 0);

        // R4 receive-only clear, transmit untouched, rdata kept
        rpush(8'h31); rpush(8'h32); rpop(); rpush(8'h33); tpush(8'h44);
        wr(8'h03, 0);
        chk("R4 rx cleared", rx_count, 0);
        chk("R4 tx kept", tx_count, 1);
        chk("R4 rdata kept", rx_rdata, 8'h31);
        chk("R4 clear bits read 0", fcr_rdata[2:1], 0);
        chk("R11 clear keeps tx_irq low", tx_irq, 0);
        wr(8'h05, 0);
        chk("R11 tx clear raises irq", tx_irq, 1);

        // R6 DMA flag
        wr(8'h09, 0);
        chk("R6 dma on", dma_mode, 1);
        chk("R6 dma readback", fcr_rdata[3], 1);
        wr(8'h01, 0);

        // R7/R8 trigger selection
        wr(8'h31, 0);
        chk("R7 tx field locked", fcr_rdata[5:4], 0);
        chk("R7 level stays 1", trig_level, 1);
        wr(8'h41, 1);
        chk("R7 rx code 01 -> 4", trig_level, 4);
        wr(8'h71, 1);
        chk("R8 tx changed last -> 14", trig_level, 14);
        wr(8'hB1, 1);
        chk("R8 rx changed last -> 8", trig_level, 8);
        wr(8'h21, 1);
        chk("R8 both change, rx wins -> 1", trig_level, 1);
        wr(8'hC1, 0);
        chk("R7 rx code 11 -> 14", trig_level, 14);
        wr(8'h41, 1);
        chk("R7 level 4 set", trig_level, 4);

        // R9 receive request at level 4
        for (int i = 0; i < 3; i++) rpush(8'(i));
        chk("R9 below level", rx_irq, 0);
        rpush(8'h03);
        chk("R9 at level", rx_irq, 1);
        rpop();
        chk("R9 pop below clears", rx_irq, 0);
        wr(8'h43, 1);

        // R10/R11 shallow refill: quiet until empty
        tpush(8'h01); tpush(8'h02);
        chk("R11 push clears tx_irq", tx_irq, 0);
        tpop();
        chk("R10 shallow count 1 quiet", tx_irq, 0);
        tpop();
        chk("R10 shallow empty fires", tx_irq, 1);
        // deep refill: fires below level
        for (int i = 0; i < 6; i++) tpush(8'(i));
        tpop(); tpop();
        chk("R10 deep at level quiet", tx_irq, 0);
        tpop();
        chk("R10 deep below level fires", tx_irq, 1);
        tpop(); tpop(); tpop();
        chk("R10 no refire on drain", tx_irq, 1);

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            tx_push = ($urandom_range(0, 99) < 50); tx_wdata = 8'($urandom());
            tx_pop  = ($urandom_range(0, 99) < 45);
            rx_push = ($urandom_range(0, 99) < 45); rx_wdata = 8'($urandom());
            rx_pop  = ($urandom_range(0, 99) < 50);
            efr_enh = $urandom_range(0, 1);
            if (r < 4) begin
                fcr_we = 1;
                fcr_wdata = 8'($urandom());
                fcr_wdata[0] = ($urandom_range(0, 7) != 0);
                if ($urandom_range(0, 3) != 0) fcr_wdata[2:1] = 2'b00;
            end
            cyc();
        end
        finish_up();
    end
endmodule